// File: doc/BRIEF.md
# DDR write data strobe sequencer

This block drives one byte lane of a double-data-rate write burst. A request carries eight data bytes and eight mask bits. Once it is accepted, the block waits a programmed number of clock cycles. It then enables the strobe and drives it low through a preamble. Next it sends the eight beats, with the strobe changing level once per beat, and then holds the strobe low for a postamble before the lane is released to high impedance.

Data and mask are launched from falling-edge registers, while the strobe follows the rising edge. Each strobe transition therefore falls in the middle of its data window, which gives the quarter-period offset a write needs. If a new request arrives with zero latency during the seventh beat, it is chained onto the current burst. The strobe keeps alternating and the data enable stays high, with no postamble or preamble in between. Requests at any other time while the lane is busy are held off.

Top module: `wr_strobe_seq`

## Requirements
- R1: While rst_ni is low, dqs_o, dqs_oe_o, dq_o, dm_o and dq_oe_o are all 0 and req_ready_o is 1; asserting reset in the middle of a burst releases the lane at once.
- R2: req_ready_o is 1 whenever the lane is idle, and a request is accepted on a rising edge where req_valid_i and req_ready_o are both 1.
- R3: After the accepting edge, dqs_oe_o stays 0 for wr_lat_i full cycles and rises at rising edge number wr_lat_i+1 counted from that edge; wr_lat_i is sampled only at acceptance.
- R4: The strobe is driven low for two cycles before its first transition: the enable cycle and one preamble cycle.
- R5: The burst then makes exactly eight strobe transitions, one on each rising edge, starting with a rise, so the strobe is high on even beats and low on odd beats.
- R6: Beat k carries req_data_i[8k+7:8k] on dq_o and req_mask_i[k] on dm_o, with beat 0 first.
- R7: dq_o, dm_o and dq_oe_o change only on falling edges. Each beat is presented half a cycle before the strobe transition that belongs to it, and dq_oe_o is high for exactly eight cycles per burst.
- R8: After the last strobe transition, which is a fall, the strobe stays driven low for one more cycle. dqs_oe_o then drops and req_ready_o returns to 1.
- R9: Whenever dqs_oe_o is 0, dqs_o, dq_oe_o, dq_o and dm_o are 0.
- R10: With wr_lat_i equal to 0, req_ready_o is also 1 during beat 6. A request accepted there starts its beat 0 on the rising edge right after beat 7, without a postamble or preamble, and the strobe keeps alternating.
- R11: A request presented while the lane is busy, outside the R10 window, is not accepted and does not change the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; strobe on rising edges, data on falling edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_data_i | input | 64 | Eight data bytes, beat 0 in the low byte |
| req_mask_i | input | 8 | Mask bit per beat, beat 0 in bit 0 |
| wr_lat_i | input | 4 | Idle cycles between acceptance and strobe enable |
| dq_o | output | 8 | Data byte of the current beat |
| dm_o | output | 1 | Mask bit of the current beat |
| dq_oe_o | output | 1 | Data and mask output enable |
| dqs_o | output | 1 | Strobe level |
| dqs_oe_o | output | 1 | Strobe output enable |

## Verification
The bench samples both a quarter period after each rising edge and again after the falling edge. A design that launched data on the rising edge, or one beat late, would show the wrong byte at one of those two points. Latencies 0 and 15 bracket the wait counter, and an off-by-one count moves the strobe enable by a cycle. The chained burst checks that beat 7 of the first request still leaves intact and that the new beat 0 follows with no low gap. A design that overwrote the buffer early or re-entered the preamble would break one of these. A request held high across a whole busy burst must leave the lane idle afterwards, which exposes a ready signal that leaks outside its window.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_OE_ON,
    ST_PRE,
    ST_BURST,
    ST_POST
  } wsq_state_e;
endpackage

// File: rtl/wsq_ctrl.sv
module wsq_ctrl #(
  parameter int BEATS = 8,
  parameter int LAT_W = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [LAT_W-1:0]     wr_lat_i,
  output logic                 req_ready_o,
  output logic                 accept_o,
  output wsq_pkg::wsq_state_e  state_o,
  output logic [IDX_W-1:0]     beat_o,
  output logic                 pend_o
);
  import wsq_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);
  localparam logic [IDX_W-1:0] CHAIN = IDX_W'(BEATS - 2);

  wsq_state_e       state_q;
  logic [LAT_W-1:0] cnt_q;
  logic [IDX_W-1:0] beat_q;
  logic             pend_q;

  // chaining window: second to last beat, zero latency, nothing queued
  assign req_ready_o = (state_q == ST_IDLE) ||
                       (state_q == ST_BURST && beat_q == CHAIN &&
                        wr_lat_i == '0 && !pend_q);
  assign accept_o = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            if (wr_lat_i == '0) begin
              state_q <= ST_OE_ON;
            end else begin
              state_q <= ST_WAIT;
              cnt_q   <= wr_lat_i - 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) state_q <= ST_OE_ON;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_OE_ON: state_q <= ST_PRE;
        ST_PRE: begin
          state_q <= ST_BURST;
          beat_q  <= '0;
        end
        ST_BURST: begin
          if (accept_o) pend_q <= 1'b1;
          if (beat_q == LAST) begin
            beat_q <= '0;
            if (pend_q) pend_q <= 1'b0;
            else state_q <= ST_POST;
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        ST_POST: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/wsq_store.sv
module wsq_store #(
  parameter int BEATS = 8,
  parameter int DQ_W  = 8,
  localparam int DATA_W = BEATS * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BEATS-1:0]  mask_i,
  output logic [DATA_W-1:0] data_o,
  output logic [BEATS-1:0]  mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mask_o <= '0;
    end else if (load_i) begin
      data_o <= data_i;
      mask_o <= mask_i;
    end
  end
endmodule

// File: rtl/wsq_launch.sv
module wsq_launch #(
  parameter int BEATS = 8,
  parameter int DQ_W  = 8,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int DATA_W = BEATS * DQ_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wsq_pkg::wsq_state_e state_i,
  input  logic [IDX_W-1:0]    beat_i,
  input  logic                pend_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [BEATS-1:0]    mask_i,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dm_o,
  output logic                dq_oe_o
);
  import wsq_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  logic [DQ_W-1:0] bytes [BEATS];
  logic            launch;
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < BEATS; g++) begin : g_bytes
    assign bytes[g] = data_i[g*DQ_W +: DQ_W];
  end

  // falling edge ahead of each strobe transition carries the next beat
  always_comb begin
    launch = 1'b0;
    sel    = '0;
    if (state_i == ST_PRE) begin
      launch = 1'b1;
    end else if (state_i == ST_BURST) begin
      if (beat_i != LAST) begin
        launch = 1'b1;
        sel    = beat_i + 1'b1;
      end else begin
        launch = pend_i;
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dm_o    <= 1'b0;
      dq_oe_o <= 1'b0;
    end else begin
      dq_oe_o <= launch;
      dq_o    <= launch ? bytes[sel] : '0;
      dm_o    <= launch && mask_i[sel];
    end
  end
endmodule

// File: rtl/wr_strobe_seq.sv
module wr_strobe_seq #(
  parameter int BEATS = 8,
  parameter int DQ_W  = 8,
  parameter int LAT_W = 4,
  localparam int IDX_W  = $clog2(BEATS),
  localparam int DATA_W = BEATS * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [BEATS-1:0]  req_mask_i,
  input  logic [LAT_W-1:0]  wr_lat_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dm_o,
  output logic              dq_oe_o,
  output logic              dqs_o,
  output logic              dqs_oe_o
);
  import wsq_pkg::*;

  wsq_state_e       state;
  logic [IDX_W-1:0] beat;
  logic             pend;
  logic             accept;
  logic [DATA_W-1:0] data_q;
  logic [BEATS-1:0]  mask_q;

  wsq_ctrl #(.BEATS(BEATS), .LAT_W(LAT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .wr_lat_i    (wr_lat_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .state_o     (state),
    .beat_o      (beat),
    .pend_o      (pend)
  );

  wsq_store #(.BEATS(BEATS), .DQ_W(DQ_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (req_data_i),
    .mask_i (req_mask_i),
    .data_o (data_q),
    .mask_o (mask_q)
  );

  wsq_launch #(.BEATS(BEATS), .DQ_W(DQ_W)) u_launch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .beat_i  (beat),
    .pend_i  (pend),
    .data_i  (data_q),
    .mask_i  (mask_q),
    .dq_o    (dq_o),
    .dm_o    (dm_o),
    .dq_oe_o (dq_oe_o)
  );

  // strobe decoded straight from rising-edge state flops
  assign dqs_oe_o = (state == ST_OE_ON) || (state == ST_PRE) ||
                    (state == ST_BURST) || (state == ST_POST);
  assign dqs_o    = (state == ST_BURST) && !beat[0];
endmodule

// File: rtl/wsq_chk.sv
module wsq_chk #(
  parameter int DQ_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic [DQ_W-1:0] dq_o,
  input logic            dm_o,
  input logic            dq_oe_o,
  input logic            dqs_o,
  input logic            dqs_oe_o
);
  assert_lane_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dqs_oe_o |-> (!dqs_o && !dq_oe_o && dq_o == '0 && !dm_o));

  assert_preamble_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> !dqs_o);

  assert_preamble_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |=> (dqs_oe_o && !dqs_o));

  assert_toggle_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_o != $past(dqs_o)) |-> $past(dq_oe_o));

  assert_data_under_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> dqs_oe_o);

  assert_postamble_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dqs_oe_o) |-> (!$past(dqs_o) && !$past(dq_oe_o)));

  assert_ready_only_chain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && dqs_oe_o) |-> (dq_oe_o && dqs_o));
endmodule

bind wr_strobe_seq wsq_chk #(.DQ_W(DQ_W)) u_wsq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .dq_o        (dq_o),
  .dm_o        (dm_o),
  .dq_oe_o     (dq_oe_o),
  .dqs_o       (dqs_o),
  .dqs_oe_o    (dqs_oe_o)
);

// File: tb/wr_strobe_seq_test.sv
`timescale 1ns/1ps
module wr_strobe_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_data = '0;
  logic [7:0]  req_mask = '0;
  logic [3:0]  wr_lat = '0;
  logic [7:0]  dq;
  logic        dm, dq_oe, dqs, dqs_oe;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wr_strobe_seq uut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_data_i (req_data), .req_mask_i (req_mask), .wr_lat_i (wr_lat),
    .dq_o (dq), .dm_o (dm), .dq_oe_o (dq_oe), .dqs_o (dqs), .dqs_oe_o (dqs_oe)
  );

  // {lat, data, mask}
  localparam logic [75:0] VEC [6] = '{
    {4'd0,  64'h0706050403020100, 8'h00},
    {4'd1,  64'hA5A5_5A5A_FF00_00FF, 8'hFF},
    {4'd3,  64'h1122_3344_5566_7788, 8'h96},
    {4'd15, 64'hDEAD_BEEF_CAFE_F00D, 8'h01},
    {4'd7,  64'h8000_0000_0000_0001, 8'h80},
    {4'd2,  64'hFFFF_FFFF_FFFF_FFFF, 8'h5A}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // packed as {dqs_oe, dqs, dq_oe, dq, dm}
  task automatic lane(input bit oe, input bit s, input bit doe, input logic [7:0] d, input bit m, input string tag);
    logic [11:0] act, exp;
    act = {dqs_oe, dqs, dq_oe, dq, dm};
    exp = {oe, s, doe, d, m};
    chk(act == exp, tag, 64'(act), 64'(exp));
  endtask

  task automatic burst(input logic [3:0] lat, input logic [63:0] d, input logic [7:0] m, input bit hold);
    wr_lat = lat; req_data = d; req_mask = m; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 64'd1);
    step;
    if (hold) req_data = ~d;
    else req_valid = 1'b0;
    for (int s = 0; s < int'(lat); s++) begin
      lane(0, 0, 0, 8'h00, 0, "R3 latency wait");
      chk(req_ready == 1'b0, "R11 not ready while waiting", 64'(req_ready), 64'd0);
      step;
    end
    lane(1, 0, 0, 8'h00, 0, "R3 strobe enable");
    step;
    lane(1, 0, 0, 8'h00, 0, "R4 preamble low");
    step;
    for (int j = 0; j < 8; j++) begin
      lane(1, (j % 2) == 0, 1, d[j*8 +: 8], m[j], "R5 R6 beat");
      chk(req_ready == (j == 6 && lat == 4'd0),
          "R10 R11 ready window", 64'(req_ready), 64'(j == 6 && lat == 4'd0));
      #2;
      if (j < 7) lane(1, (j % 2) == 0, 1, d[(j+1)*8 +: 8], m[j+1], "R7 next beat at falling edge");
      else lane(1, 0, 0, 8'h00, 0, "R7 data released at falling edge");
      step;
    end
    lane(1, 0, 0, 8'h00, 0, "R8 postamble");
    step;
    lane(0, 0, 0, 8'h00, 0, "R8 R9 lane released");
    chk(req_ready == 1'b1, "R8 ready after burst", 64'(req_ready), 64'd1);
    req_valid = 1'b0;
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    lane(0, 0, 0, 8'h00, 0, "R1 reset outputs");
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    step;
    lane(0, 0, 0, 8'h00, 0, "R9 idle lane");

    for (int i = 0; i < 6; i++) begin
      burst(VEC[i][75:72], VEC[i][71:8], VEC[i][7:0], 1'b0);
      step;
    end

    // R11: request held high through a busy burst
    burst(4'd3, 64'h0123_4567_89AB_CDEF, 8'h3C, 1'b1);
    for (int k = 0; k < 4; k++) begin
      step;
      lane(0, 0, 0, 8'h00, 0, "R11 no late acceptance");
    end

    // R10: chained burst
    wr_lat = 4'd0;
    req_data = 64'h1111_2222_3333_4444; req_mask = 8'hC3; req_valid = 1'b1;
    step;
    req_valid = 1'b0;
    lane(1, 0, 0, 8'h00, 0, "R3 zero latency enable");
    step;
    lane(1, 0, 0, 8'h00, 0, "R4 preamble chained case");
    step;
    for (int b = 0; b < 2; b++) begin
      logic [63:0] d;
      logic [7:0]  m;
      d = (b == 0) ? 64'h1111_2222_3333_4444 : 64'h9A8B_7C6D_5E4F_3021;
      m = (b == 0) ? 8'hC3 : 8'h2D;
      for (int j = 0; j < 8; j++) begin
        if (j == 7) req_valid = 1'b0;
        lane(1, (j % 2) == 0, 1, d[j*8 +: 8], m[j], "R10 chained beat");
        if (j == 6) begin
          chk(req_ready == 1'b1, "R10 ready in beat 6", 64'(req_ready), 64'd1);
          if (b == 0) begin
            req_valid = 1'b1;
            req_data = 64'h9A8B_7C6D_5E4F_3021;
            req_mask = 8'h2D;
          end
        end
        #2;
        if (j < 7) lane(1, (j % 2) == 0, 1, d[(j+1)*8 +: 8], m[j+1], "R7 chained falling edge");
        else if (b == 0) lane(1, 0, 1, 8'h21, 1, "R10 next burst beat 0 launched");
        else lane(1, 0, 0, 8'h00, 0, "R7 chained release");
        step;
      end
    end
    lane(1, 0, 0, 8'h00, 0, "R8 postamble after chain");
    step;
    lane(0, 0, 0, 8'h00, 0, "R8 idle after chain");

    // R1: reset in the middle of a burst
    step;
    wr_lat = 4'd0; req_data = 64'hFEDC_BA98_7654_3210; req_mask = 8'hFF; req_valid = 1'b1;
    step;
    req_valid = 1'b0;
    step; step; step; step;
    lane(1, 1, 1, 8'h54, 1, "R6 beat 2 before reset");
    rst_n = 1'b0;
    #0.5;
    lane(0, 0, 0, 8'h00, 0, "R1 asynchronous release");
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    step;
    rst_n = 1'b1;
    step; step;
    lane(0, 0, 0, 8'h00, 0, "R1 idle after reset release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule